// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small nonvolatile memory of 64 words of 16 bits behind a three-wire serial slave port: a select line, a serial clock, a serial data input and a serial data output with an output-enable. All logic runs on a fast system clock. The three serial inputs pass through synchronisers, and serial clock edges are found by oversampling. The host selects the device and shifts in a start bit, an opcode, an address and, for store commands, a data word. A read returns a word. A write-type command arms a program cycle that the falling select line launches.

The program cycle is self-timed. It lasts a configurable number of system clocks and needs no further serial clocks. If the host selects the device again while the cycle runs, the data output reports busy as low and ready as high. A store command only takes effect when three things hold: writes are enabled, the select line drops in the window right after the final bit, and the previous deselect lasted long enough.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset every word reads 0xFFFF, writes are disabled, and `dout_oe_o` is low.
- R2: A frame opens with the first 1 sampled on a rising serial clock edge while selected; 0s before it are ignored. Next come a 2-bit opcode and a 6-bit address, both MSB first. Opcode 10 (read) drives a 0 on the edge that samples the last address bit. On each of the following 16 rising edges it drives the next data bit, MSB first.
- R3: Opcode 00 is a special group decoded by the two upper address bits: 11 enables writes and 00 disables them. While writes are disabled, write, erase, erase-all and write-all frames change nothing. Writes start out disabled.
- R4: Opcode 01 followed by 16 data bits (MSB first) stores the word at the address, replacing any old content with no erase needed first.
- R5: Opcode 11 sets the addressed word to 0xFFFF.
- R6: Opcode 00 with upper address bits 10 sets every word to 0xFFFF.
- R7: Opcode 00 with upper address bits 01, followed by 16 data bits, stores that word in every location.
- R8: A store command starts only if select falls after the last bit is sampled and before the next rising serial clock edge. A select drop before the frame is complete, or after an extra rising edge, leaves memory unchanged.
- R9: Once started, the program cycle keeps the block busy for exactly PROG_CYCLES system clocks without any serial clock. The new contents are readable after it ends.
- R10: When the device is reselected after a program cycle has started, `dout_o` is driven low while busy and high once ready. Serial clock edges are ignored while busy. The first start bit accepted afterwards ends the status display.
- R11: `dout_oe_o` is low whenever select has been low for the synchroniser latency.
- R12: If select is reasserted less than CS_LOW_MIN system clocks after it was dropped, the whole selection is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial read data or ready/busy status |
| dout_oe_o | output | 1 | Output enable for `dout_o`; low means high-impedance |

## Verification
The bench builds the block with PROG_CYCLES = 300 and CS_LOW_MIN = 6. The address and data widths stay at their defaults, so the corner addresses 0 and 63 are reached. With the short program time, the bench can poll busy through to ready inside the run and bound the measured busy length. The program time is still long enough that a whole erase frame fits inside the busy window, which shows that frames sent while busy are dropped. The small minimum deselect time lets a two-clock select gap void an enable command while the normal twelve-clock gaps still pass.

// File: rtl/uw_pkg.sv
package uw_pkg;
  localparam logic [1:0] OP_SPEC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_FILL = 2'b01;
  localparam logic [1:0] SUB_CLR  = 2'b10;
  localparam logic [1:0] SUB_EN   = 2'b11;

  typedef enum logic [1:0] {
    CMD_WORD_SET,
    CMD_WORD_CLR,
    CMD_ALL_CLR,
    CMD_ALL_SET
  } cmd_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HDR,
    FR_DATA,
    FR_READ,
    FR_ARMED,
    FR_DONE
  } frame_e;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/uw_frame.sv
module uw_frame
  import uw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          sck_rise_i,
  input  logic          sdi_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          go_o,
  output cmd_e          kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          en_set_o,
  output logic          en_clr_o,
  output logic          start_o,
  output logic          rd_act_o,
  output logic          rd_bit_o
);
  localparam int HW   = 2 + AW;
  localparam int MAXB = (HW > DW) ? HW : DW;
  localparam int CW   = $clog2(MAXB + 1);

  frame_e        st_q;
  cmd_e          kind_q;
  logic [HW-1:0] hdr_q;
  logic [HW-1:0] hdr_nx;
  logic [DW-1:0] dat_q;
  logic [DW:0]   rsr_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          sel_q;
  logic          adv;
  logic          hdr_last;
  logic [1:0]    op_nx;
  logic [1:0]    sub_nx;

  assign adv      = sel_i & sck_rise_i & ~busy_i;
  assign hdr_nx   = {hdr_q[HW-2:0], sdi_i};
  assign op_nx    = hdr_nx[HW-1:HW-2];
  assign sub_nx   = hdr_nx[AW-1:AW-2];
  assign hdr_last = adv && (st_q == FR_HDR) && (cnt_q == CW'(HW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      kind_q <= CMD_WORD_SET;
      hdr_q  <= '0;
      dat_q  <= '0;
      rsr_q  <= '1;
      cnt_q  <= '0;
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (!sel_i) begin
        st_q  <= FR_IDLE;
        cnt_q <= '0;
      end else if (adv) begin
        unique case (st_q)
          FR_IDLE: if (sdi_i) begin
            st_q  <= FR_HDR;
            cnt_q <= '0;
          end
          FR_HDR: begin
            hdr_q <= hdr_nx;
            if (cnt_q == CW'(HW - 1)) begin
              cnt_q  <= '0;
              addr_q <= hdr_nx[AW-1:0];
              unique case (op_nx)
                OP_READ: begin
                  rsr_q <= {1'b0, rd_data_i};
                  st_q  <= FR_READ;
                end
                OP_WRITE: begin
                  kind_q <= CMD_WORD_SET;
                  st_q   <= FR_DATA;
                end
                OP_ERASE: begin
                  kind_q <= CMD_WORD_CLR;
                  st_q   <= FR_ARMED;
                end
                default: begin
                  unique case (sub_nx)
                    SUB_CLR: begin
                      kind_q <= CMD_ALL_CLR;
                      st_q   <= FR_ARMED;
                    end
                    SUB_FILL: begin
                      kind_q <= CMD_ALL_SET;
                      st_q   <= FR_DATA;
                    end
                    default: st_q <= FR_DONE;
                  endcase
                end
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FR_DATA: begin
            dat_q <= {dat_q[DW-2:0], sdi_i};
            if (cnt_q == CW'(DW - 1)) st_q <= FR_ARMED;
            else                      cnt_q <= cnt_q + 1'b1;
          end
          FR_READ:  rsr_q <= {rsr_q[DW-1:0], 1'b1};
          // an edge inside the arming window cancels the command
          FR_ARMED: st_q <= FR_DONE;
          default:  ;
        endcase
      end
    end
  end

  assign rd_addr_o = hdr_nx[AW-1:0];
  assign go_o      = sel_q & ~sel_i & (st_q == FR_ARMED);
  assign kind_o    = kind_q;
  assign addr_o    = addr_q;
  assign data_o    = dat_q;
  assign en_set_o  = hdr_last && (op_nx == OP_SPEC) && (sub_nx == SUB_EN);
  assign en_clr_o  = hdr_last && (op_nx == OP_SPEC) && (sub_nx == SUB_DIS);
  assign start_o   = adv && (st_q == FR_IDLE) && sdi_i;
  assign rd_act_o  = (st_q == FR_READ);
  assign rd_bit_o  = rsr_q[DW];
endmodule

// File: rtl/uw_prog.sv
module uw_prog
  import uw_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  cmd_e          kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o
);
  localparam int DEPTH = 1 << AW;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  cmd_e          kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] tmr_q;
  logic          busy_q;
  logic          commit;
  logic          all_q;
  logic [DW-1:0] wdata;
  logic [DEPTH-1:0][DW-1:0] words;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= CMD_WORD_SET;
      addr_q <= '0;
      data_q <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else if (go_i && !busy_q) begin
      kind_q <= kind_i;
      addr_q <= addr_i;
      data_q <= data_i;
      tmr_q  <= TW'(PROG_CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

  assign commit = busy_q && (tmr_q == '0);
  assign all_q  = (kind_q == CMD_ALL_CLR) || (kind_q == CMD_ALL_SET);
  // clear kinds load ones; set kinds overwrite directly (auto-clear)
  assign wdata  = ((kind_q == CMD_WORD_CLR) || (kind_q == CMD_ALL_CLR)) ? '1 : data_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q <= '1;
      else if (commit && (all_q || (addr_q == AW'(i))))
        word_q <= wdata;
    end
    assign words[i] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
  assign busy_o    = busy_q;
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int CS_LOW_MIN  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);
  localparam int LW = $clog2(CS_LOW_MIN + 1);

  logic              cs_s, sclk_s, din_s;
  logic              cs_q, sclk_q;
  logic [LW-1:0]     low_cnt_q;
  logic              sel_ok_q;
  logic              sel;
  logic              sck_rise;
  logic              wen_q;
  logic              stat_q;
  logic              busy;
  logic              frame_go;
  logic              prog_go;
  cmd_e              kind;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [DATA_W-1:0] data, rd_data;
  logic              en_set, en_clr, start, rd_act, rd_bit;

  uw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sclk_i, din_i}),
    .q_o    ({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= 1'b0;
      sclk_q    <= 1'b0;
      low_cnt_q <= LW'(CS_LOW_MIN);
      sel_ok_q  <= 1'b0;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      if (!cs_s) begin
        if (low_cnt_q != LW'(CS_LOW_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
      end else if (!cs_q) begin
        // selection is valid only after a long enough deselect
        sel_ok_q  <= (low_cnt_q >= LW'(CS_LOW_MIN));
        low_cnt_q <= '0;
      end
      if (en_set)      wen_q <= 1'b1;
      else if (en_clr) wen_q <= 1'b0;
      if (prog_go)     stat_q <= 1'b1;
      else if (start)  stat_q <= 1'b0;
    end
  end

  assign sel      = cs_s & sel_ok_q;
  assign sck_rise = sclk_s & ~sclk_q;
  assign prog_go  = frame_go & wen_q & ~busy;

  uw_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .sck_rise_i (sck_rise),
    .sdi_i      (din_s),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .go_o       (frame_go),
    .kind_o     (kind),
    .addr_o     (addr),
    .data_o     (data),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .start_o    (start),
    .rd_act_o   (rd_act),
    .rd_bit_o   (rd_bit)
  );

  uw_prog #(.AW(ADDR_W), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (prog_go),
    .kind_i    (kind),
    .addr_i    (addr),
    .data_i    (data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );

  assign dout_oe_o = sel & (stat_q | rd_act);
  assign dout_o    = stat_q ? ~busy : rd_bit;
endmodule

// File: rtl/uw_chk.sv
module uw_chk #(
  parameter int PROG_CYCLES = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic busy,
  input logic prog_go,
  input logic frame_go,
  input logic wen_q,
  input logic sel,
  input logic stat_q
);
  logic [31:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= '0;
    else if (busy) len_q <= len_q + 1;
    else           len_q <= '0;
  end

  // valid for the default two-stage synchroniser
  assert_oe_off_deselected_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && $past(!cs_i) && $past(!cs_i, 2) && $past(!cs_i, 3)) |-> !dout_oe_o);

  assert_busy_needs_go_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(prog_go));

  assert_busy_length_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (len_q == 32'(PROG_CYCLES)));

  assert_disabled_no_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_go && !wen_q && !busy) |=> !busy);

  assert_status_low_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && stat_q && busy) |-> (dout_oe_o && !dout_o));

  assert_no_restart_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !prog_go);
endmodule

bind uwire_eeprom uw_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .busy      (busy),
  .prog_go   (prog_go),
  .frame_go  (frame_go),
  .wen_q     (wen_q),
  .sel       (sel),
  .stat_q    (stat_q)
);

// File: tb/sim_uwire_eeprom.sv
module sim_uwire_eeprom;
  localparam int PROG = 300;
  localparam int CSMIN = 6;
  localparam logic [1:0] K_SPEC = 2'b00, K_WR = 2'b01, K_RD = 2'b10, K_ER = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uwire_eeprom #(
    .ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG), .CS_LOW_MIN(CSMIN), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk(input logic b, output logic q);
    din = b;
    clks(4);
    sclk = 1'b1;
    clks(8);
    q = dout;
    sclk = 1'b0;
    clks(4);
  endtask

  task automatic sel_dev();
    cs = 1'b1;
    clks(4);
  endtask

  task automatic desel();
    cs = 1'b0;
    clks(12);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [5:0] a, output logic dq);
    logic q;
    sk(1'b1, q);
    sk(op[1], q);
    sk(op[0], q);
    for (int i = 5; i >= 0; i--) sk(a[i], q);
    dq = q;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                     input int nd, input int extra);
    logic q;
    sel_dev();
    hdr(op, a, q);
    for (int i = 15; i > 15 - nd; i--) sk(d[i], q);
    for (int i = 0; i < extra; i++) sk(1'b0, q);
    desel();
  endtask

  task automatic wait_prog();
    clks(PROG + 20);
  endtask

  task automatic rd(input logic [5:0] a, input int lead, output logic [15:0] d, output logic dum);
    logic q;
    sel_dev();
    for (int i = 0; i < lead; i++) sk(1'b0, q);
    hdr(K_RD, a, dum);
    for (int i = 15; i >= 0; i--) begin
      sk(1'b0, q);
      d[i] = q;
    end
    desel();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cmd(K_WR, a, d, 16, 0);
    wait_prog();
  endtask

  task automatic ewen();  cmd(K_SPEC, 6'h30, 16'h0, 0, 0); endtask
  task automatic ewds();  cmd(K_SPEC, 6'h00, 16'h0, 0, 0); endtask

  task automatic t_reset();
    logic [15:0] d;
    logic dum;
    chk("R1 oe after reset", 32'(dout_oe), 32'h0);
    rd(6'd0, 0, d, dum);
    chk("R1 word0", 32'(d), 32'hFFFF);
    chk("R2 dummy bit", 32'(dum), 32'h0);
    rd(6'd63, 0, d, dum);
    chk("R1 word63", 32'(d), 32'hFFFF);
    chk("R11 oe after deselect", 32'(dout_oe), 32'h0);
    wr(6'd1, 16'h0000);
    rd(6'd1, 0, d, dum);
    chk("R3 powerup disabled", 32'(d), 32'hFFFF);
  endtask

  task automatic t_short_gap();
    logic [15:0] d;
    logic q;
    sel_dev();
    hdr(K_RD, 6'd0, q);
    for (int i = 0; i < 16; i++) sk(1'b0, q);
    cs = 1'b0;
    clks(2);
    sel_dev();
    hdr(K_SPEC, 6'h30, q);
    desel();
    wr(6'd3, 16'h1234);
    rd(6'd3, 0, d, q);
    chk("R12 short gap voids enable", 32'(d), 32'hFFFF);
    ewen();
    wr(6'd3, 16'h1234);
    rd(6'd3, 0, d, q);
    chk("R4 write", 32'(d), 32'h1234);
  endtask

  task automatic t_overwrite_erase();
    logic [15:0] d;
    logic q;
    wr(6'd3, 16'h0F0F);
    rd(6'd3, 0, d, q);
    chk("R4 overwrite no erase", 32'(d), 32'h0F0F);
    cmd(K_ER, 6'd3, 16'h0, 0, 0);
    wait_prog();
    rd(6'd3, 0, d, q);
    chk("R5 erase", 32'(d), 32'hFFFF);
  endtask

  task automatic t_window();
    logic [15:0] d;
    logic q;
    cmd(K_WR, 6'd5, 16'hA5A5, 16, 1);
    wait_prog();
    rd(6'd5, 0, d, q);
    chk("R8 late deselect", 32'(d), 32'hFFFF);
    cmd(K_WR, 6'd6, 16'h0000, 15, 0);
    wait_prog();
    rd(6'd6, 0, d, q);
    chk("R8 early deselect", 32'(d), 32'hFFFF);
    wr(6'd5, 16'hA5A5);
    rd(6'd5, 0, d, q);
    chk("R8 in-window deselect", 32'(d), 32'hA5A5);
  endtask

  task automatic t_status();
    logic [15:0] d;
    logic q;
    int cnt;
    sel_dev();
    hdr(K_WR, 6'd7, q);
    for (int i = 15; i >= 0; i--) sk(((16'h5A5A >> i) & 16'h1) != 0, q);
    cs = 1'b0;
    cnt = 0;
    clks(12); cnt += 12;
    cs = 1'b1;
    clks(4);  cnt += 4;
    chk("R10 status oe", 32'(dout_oe), 32'h1);
    chk("R10 busy low", 32'(dout), 32'h0);
    // full erase frame while busy must be dropped
    for (int i = 0; i < 9; i++) begin
      sk((i == 0) || (i == 1) || (i == 2) || (i == 6) || (i == 8), q);
      cnt += 16;
    end
    cs = 1'b0;
    clks(12); cnt += 12;
    cs = 1'b1;
    clks(4);  cnt += 4;
    chk("R10 still busy", 32'(dout), 32'h0);
    while (dout !== 1'b1 && cnt < 3000) begin
      clks(1);
      cnt++;
    end
    chk("R9 busy ends in window", 32'((cnt >= PROG) && (cnt <= PROG + 8)), 32'h1);
    chk("R10 ready high", 32'(dout), 32'h1);
    desel();
    rd(6'd7, 0, d, q);
    chk("R9 program result", 32'(d), 32'h5A5A);
    rd(6'd5, 0, d, q);
    chk("R10 frame ignored while busy", 32'(d), 32'hA5A5);
  endtask

  task automatic t_bulk();
    logic [15:0] d;
    logic q;
    cmd(K_SPEC, 6'h10, 16'hC3C3, 16, 0);
    wait_prog();
    rd(6'd0, 0, d, q);
    chk("R7 fill word0", 32'(d), 32'hC3C3);
    rd(6'd63, 0, d, q);
    chk("R7 fill word63", 32'(d), 32'hC3C3);
    ewds();
    cmd(K_SPEC, 6'h20, 16'h0, 0, 0);
    wait_prog();
    rd(6'd10, 0, d, q);
    chk("R3 clear-all ignored when disabled", 32'(d), 32'hC3C3);
    ewen();
    cmd(K_SPEC, 6'h20, 16'h0, 0, 0);
    wait_prog();
    rd(6'd0, 0, d, q);
    chk("R6 clear word0", 32'(d), 32'hFFFF);
    rd(6'd63, 0, d, q);
    chk("R6 clear word63", 32'(d), 32'hFFFF);
  endtask

  task automatic t_lead_zeros();
    logic [15:0] d;
    logic q;
    wr(6'd40, 16'h8001);
    rd(6'd40, 3, d, q);
    chk("R2 leading zeros read", 32'(d), 32'h8001);
    chk("R2 dummy after zeros", 32'(q), 32'h0);
    chk("R11 oe low at end", 32'(dout_oe), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);
    t_reset();
    t_short_gap();
    t_overwrite_erase();
    t_window();
    t_status();
    t_bulk();
    t_lead_zeros();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule